// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block chooses which of a serial port's interrupt sources a driver sees. It takes the interrupt enable bits, the line status flags, a character-timeout flag, the receive FIFO fill level and trigger threshold, a transmitter-empty event and the modem-status change bits. From these it produces a registered identification byte and a level interrupt line. The identification byte holds a 4-bit cause code in its low nibble and a FIFO-enabled marker in its top two bits.

The block also owns two pieces of state: the enable register and the transmitter-empty pending flag. Reading the identification byte clears that pending flag. Writing the enable register can set it again. Both outputs are evaluated from the state that the same clock edge produces, so a read or write and its effect on the interrupt appear together.

Top module: `uart_irq_ident`

## Requirements
- R1: Reset sets the identification byte to 0x01, drops the interrupt, clears the enable register and clears the transmitter-empty pending flag.
- R2: An enable write stores bits 3:0 of the written byte and discards bits 7:4. The stored value is visible on `ier`. Enable bit 0 is receive data, bit 1 is transmitter empty, bit 2 is line status and bit 3 is modem status.
- R3: While the enable register is zero, `irq` stays low and the cause code is 0x01 whatever is pending.
- R4: Causes rank from first to last as line status (code 0x6), character timeout (0xC), receive data (0x4), transmitter empty (0x2) and modem status (0x0). With no active cause the code is 0x1 and `irq` is low. Otherwise `irq` is high.
- R5: Line status is active when enable bit 2 is set and any of `line_stat` bits 1 to 4 is set. Bits 5 to 7 of `line_stat` have no effect.
- R6: Character timeout is active whenever `tmo_pend` is high and the enable register is non-zero. It has no enable bit of its own.
- R7: Receive data needs enable bit 0 and `line_stat` bit 0. With `fifo_en` high it also needs `rx_count` >= `rx_trig`.
- R8: The transmitter-empty pending flag is set by a `thre_set` pulse. It is also set by an enable write made while `thr_empty` is high.
- R9: An identification read (`iir_rd`) clears the pending flag. A set in the same cycle wins over the clear.
- R10: Identification bits 7:6 both equal `fifo_en` and bits 5:4 are zero, whatever the cause code.
- R11: Modem status is active when enable bit 3 is set and any `msr_delta` bit is set.
- R12: `iir`, `irq` and `ier` change at the first rising clock edge after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Byte written to the enable register |
| iir_rd | input | 1 | Identification register read strobe |
| fifo_en | input | 1 | FIFOs enabled |
| line_stat | input | 8 | Line status: bit 0 data ready, bits 1 to 4 error/break flags |
| tmo_pend | input | 1 | Character timeout pending |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| thr_empty | input | 1 | Holding register currently empty |
| thre_set | input | 1 | Pulse: transmitter became empty |
| msr_delta | input | 4 | Modem status change bits |
| ier | output | 4 | Stored enable bits |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt |

## Verification
Every result of this block is due at the first rising edge after its stimulus. This covers the cause code, the FIFO marker, the interrupt level and the stored enable bits, and it holds even when a read or write in that cycle changes the pending flag. The bench drives inputs on the falling edge and samples on the next falling edge. That leaves exactly one rising edge between stimulus and check. In the sweep, the pending flag is set up in its own cycle, and the check reads the outputs of the edge that follows.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;

    // Source index doubles as rank: lower index wins.
    localparam int SRC_LINE  = 0;
    localparam int SRC_TMO   = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_THR   = 3;
    localparam int SRC_MODEM = 4;

    localparam logic [3:0] CODE_NONE  = 4'h1;
    localparam logic [3:0] CODE_LINE  = 4'h6;
    localparam logic [3:0] CODE_TMO   = 4'hC;
    localparam logic [3:0] CODE_RXD   = 4'h4;
    localparam logic [3:0] CODE_THR   = 4'h2;
    localparam logic [3:0] CODE_MODEM = 4'h0;

    typedef struct packed {
        logic [3:0] ier;
        logic       thr_pend;
        logic [7:0] iir;
        logic       irq;
    } ident_state_t;

    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            SRC_LINE:  return CODE_LINE;
            SRC_TMO:   return CODE_TMO;
            SRC_RXD:   return CODE_RXD;
            SRC_THR:   return CODE_THR;
            SRC_MODEM: return CODE_MODEM;
            default:   return CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_req.sv
module uart_irq_req
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]         ier_en,
    input  logic [7:0]         line_stat,
    input  logic               tmo_pend,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               thr_pend,
    input  logic [3:0]         msr_delta,
    output logic [NUM_SRC-1:0] req
);
    localparam logic [7:0] ERR_MASK = 8'h1E;
    localparam int EN_RXD   = 0;
    localparam int EN_THR   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    logic level_ok;

    always_comb begin
        level_ok       = !fifo_en || (rx_count >= rx_trig);
        req            = '0;
        req[SRC_LINE]  = ier_en[EN_LINE] && ((line_stat & ERR_MASK) != 8'h00);
        req[SRC_TMO]   = tmo_pend && (ier_en != 4'h0);
        req[SRC_RXD]   = ier_en[EN_RXD] && line_stat[0] && level_ok;
        req[SRC_THR]   = ier_en[EN_THR] && thr_pend;
        req[SRC_MODEM] = ier_en[EN_MODEM] && (msr_delta != 4'h0);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [3:0]   code
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            if (g == 0) begin : g_top
                assign grant[g] = req[g];
            end else begin : g_rest
                assign grant[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = src_code(i);
        end
    end

    // R4
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end

    // R4
    always_comb begin
        grant_cover_chk: assert ((req == '0) || (grant != '0));
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             fifo_en,
    input  logic [7:0]       line_stat,
    input  logic             tmo_pend,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thr_empty,
    input  logic             thre_set,
    input  logic [3:0]       msr_delta,
    output logic [3:0]       ier,
    output logic [7:0]       iir,
    output logic             irq
);
    localparam ident_state_t RST_STATE = '{ier: 4'h0, thr_pend: 1'b0,
                                           iir: {4'h0, CODE_NONE}, irq: 1'b0};

    ident_state_t       st_q, st_d;
    logic [3:0]         ier_d;
    logic               pend_d;
    logic [NUM_SRC-1:0] req, grant;
    logic [3:0]         code;

    // Control fields first; causes are judged on these next values.
    always_comb begin
        ier_d  = ier_wr ? ier_wdata[3:0] : st_q.ier;
        pend_d = st_q.thr_pend;
        if (iir_rd) pend_d = 1'b0;
        if (thre_set || (ier_wr && thr_empty)) pend_d = 1'b1;
    end

    uart_irq_req #(.CNT_W(CNT_W)) u_req (
        .ier_en    (ier_d),
        .line_stat (line_stat),
        .tmo_pend  (tmo_pend),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_trig   (rx_trig),
        .thr_pend  (pend_d),
        .msr_delta (msr_delta),
        .req       (req)
    );

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .req   (req),
        .grant (grant),
        .code  (code)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ier      = ier_d;
        st_d.thr_pend = pend_d;
        st_d.irq      = (ier_d != 4'h0) && (grant != '0);
        st_d.iir      = {fifo_en, fifo_en, 2'b00,
                         st_d.irq ? code : CODE_NONE};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign ier = st_q.ier;
    assign iir = st_q.iir;
    assign irq = st_q.irq;

    // R2
    ier_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier == $past(ier_wdata[3:0])));

    // R3
    ier_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'h0) |-> (!irq && (iir[3:0] == CODE_NONE)));

    // R6
    tmo_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_pend && (ier != 4'h0) && !ier_wr) |=> irq);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !thre_set && !ier_wr) |=> (iir[3:0] != CODE_THR));

    // R10
    fifo_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |=> (iir[7:4] == 4'hC));

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    localparam int CNT_W = 5;
    localparam int TRIG  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [7:0]       ier_wdata = 8'h00;
    logic             iir_rd = 1'b0;
    logic             fifo_en = 1'b0;
    logic [7:0]       line_stat = 8'h00;
    logic             tmo_pend = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trig = '0;
    logic             thr_empty = 1'b0;
    logic             thre_set = 1'b0;
    logic [3:0]       msr_delta = 4'h0;
    logic [3:0]       ier;
    logic [7:0]       iir;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .fifo_en(fifo_en), .line_stat(line_stat),
        .tmo_pend(tmo_pend), .rx_count(rx_count), .rx_trig(rx_trig),
        .thr_empty(thr_empty), .thre_set(thre_set), .msr_delta(msr_delta),
        .ier(ier), .iir(iir), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_code(input logic [3:0] en, input logic [7:0] ls,
        input logic tmo, input logic fe, input int cnt, input logic pend, input logic [3:0] md);
        if (en == 4'h0) return 4'h1;
        if (en[2] && ((ls & 8'h1E) != 0)) return 4'h6;
        if (tmo) return 4'hC;
        if (en[0] && ls[0] && (!fe || cnt >= TRIG)) return 4'h4;
        if (en[1] && pend) return 4'h2;
        if (en[3] && (md != 0)) return 4'h0;
        return 4'h1;
    endfunction

    initial begin
        #700000;
        fails++;
        $display("FAIL R12 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] ls_pat [6];
        ls_pat = '{8'h00, 8'h02, 8'h04, 8'h08, 8'h10, 8'hE0};
        rx_trig = CNT_W'(TRIG);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1 iir", iir, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 ier", {4'h0, ier}, 8'h00);
        // R1: pending cleared by reset; R2 upper bits dropped
        ier_wr = 1'b1; ier_wdata = 8'hF2;
        @(negedge clk);
        ier_wr = 1'b0;
        check("R1 pend", iir, 8'h01);
        check("R2 ier", {4'h0, ier}, 8'h02);
        // R8: thre_set pulse
        thre_set = 1'b1;
        @(negedge clk);
        thre_set = 1'b0;
        check("R8 set", iir, 8'h02);
        check("R4 irq", {7'd0, irq}, 8'h01);
        // R9: set wins over clear
        iir_rd = 1'b1; thre_set = 1'b1;
        @(negedge clk);
        thre_set = 1'b0;
        check("R9 setwins", iir, 8'h02);
        @(negedge clk);
        iir_rd = 1'b0;
        check("R9 clear", iir, 8'h01);
        // R8: enable write while holding register empty
        ier_wr = 1'b1; ier_wdata = 8'h02; thr_empty = 1'b1;
        @(negedge clk);
        ier_wr = 1'b0; thr_empty = 1'b0;
        check("R8 ierwr", iir, 8'h02);
        // R10: marker follows fifo_en within one edge
        fifo_en = 1'b1;
        @(negedge clk);
        check("R10 mark", iir, 8'hC2);
        fifo_en = 1'b0;
        @(negedge clk);
        check("R10 unmark", iir, 8'h02);

        // Sweep: R3 R4 R5 R6 R7 R11 R12
        for (int en = 0; en < 16; en++)
        for (int lp = 0; lp < 6; lp++)
        for (int dr = 0; dr < 2; dr++)
        for (int tm = 0; tm < 2; tm++)
        for (int ci = 0; ci < 3; ci++)
        for (int fe = 0; fe < 2; fe++)
        for (int mi = 0; mi < 2; mi++)
        for (int pd = 0; pd < 2; pd++) begin
            logic [3:0] md;
            logic [3:0] code;
            logic       xirq;
            md = mi[0] ? 4'(1 << ((en + lp) % 4)) : 4'h0;
            ier_wr = 1'b1; ier_wdata = {4'(en ^ lp), 4'(en)};
            iir_rd = 1'b1; thr_empty = 1'b0; thre_set = 1'b0;
            line_stat = ls_pat[lp] | 8'(dr);
            tmo_pend = tm[0]; fifo_en = fe[0];
            rx_count = CNT_W'(TRIG - 1 + ci);
            msr_delta = md;
            @(negedge clk);
            ier_wr = 1'b0; iir_rd = 1'b0; thre_set = pd[0];
            @(negedge clk);
            thre_set = 1'b0;
            code = exp_code(4'(en), line_stat, tm[0], fe[0], TRIG - 1 + ci, pd[0], md);
            xirq = (code != 4'h1);
            check("R4 iir", iir, {fe[0], fe[0], 2'b00, code});
            check("R3 irq", {7'd0, irq}, {7'd0, xirq});
            check("R2 ier", {4'h0, ier}, 8'(en));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule